// File: doc/BRIEF.md
# Two-Stage Pipeline Hazard Controller

This block is the control spine of a two-stage in-order processor pipeline. The front stage (F) fetches, decodes, reads registers and runs the ALU. The back stage (M) accesses data memory and writes results back to the register file. The controller owns the F-to-M pipeline register for the control bits and the destination register number. It compares the instruction in M against the sources of the instruction in F. It also turns a wrong-path fetch into a bubble that has no side effects.

A read-after-write conflict is resolved only by stalling. While F is stalled, the PC enable drops and the F instruction is held. M then receives one bubble, so the conflicting writer retires and the stall clears on the next cycle. When the branch logic reports a redirect, the instruction now in F is on the wrong path. It is flushed: M receives a bubble and the PC enable stays high so that the target can load. A flush always takes precedence over a stall. The instruction already in M is never touched by either action.

A dedicated no-operation word, 32'h0000000F, decodes to all-zero control. It never causes a stall. A parameter selects whether register 0 is a constant zero register. If it is, a destination of 0 never creates a hazard.

Top module: `pipe_hazard_ctl`

## Requirements
- R1: While `rst_n` is low (asynchronous, active low), all M-stage outputs (`m_wr_reg`, `m_wr_mem`, `m_rd_mem`, `m_is_br`, `m_is_jmp`, `m_dst`) are 0.
- R2: With no stall and no flush, a clock edge copies the F control bits and `f_dst` into the M outputs.
- R3: `f_stall` is 1 when `m_wr_reg`=1, `m_dst` equals `f_src1` or `f_src2`, `br_redirect`=0, `f_word` is not the NOP word, and the register-0 rule of R8 does not exempt the match.
- R4: `f_stall` is 0 when `m_wr_reg`=0 (for example a store in M) or when neither source matches `m_dst`.
- R5: During a stall, `pc_en`=0, and the next edge loads a bubble into M: all five control bits are 0 and `m_dst`=0.
- R6: `f_flush` follows `br_redirect`. During a flush, the next edge loads a bubble into M, `f_stall`=0 and `pc_en`=1, even if a hazard is present.
- R7: When `f_word`=32'h0000000F, the decoded control bits and the destination are treated as 0 and the sources are not compared. No stall results, and the next edge loads a bubble.
- R8: With `ZERO_HARDWIRED`=1, a match on register number 0 is not a hazard. With `ZERO_HARDWIRED`=0, it is treated like any other match.
- R9: Forward progress: `f_stall` is never 1 on two consecutive clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| f_word | input | 32 | Raw instruction word in F (NOP detection) |
| f_wr_reg | input | 1 | F decode: writes a register |
| f_wr_mem | input | 1 | F decode: writes data memory |
| f_rd_mem | input | 1 | F decode: reads data memory |
| f_is_br | input | 1 | F decode: conditional branch |
| f_is_jmp | input | 1 | F decode: jump |
| f_dst | input | 5 | F destination register number |
| f_src1 | input | 5 | F first source register number |
| f_src2 | input | 5 | F second source register number |
| br_redirect | input | 1 | Control flow went elsewhere; F holds a wrong-path fetch |
| m_wr_reg | output | 1 | M: register write enable |
| m_wr_mem | output | 1 | M: memory write enable |
| m_rd_mem | output | 1 | M: memory read |
| m_is_br | output | 1 | M: branch flag |
| m_is_jmp | output | 1 | M: jump flag |
| m_dst | output | 5 | M destination register number |
| f_stall | output | 1 | F is held this cycle |
| f_flush | output | 1 | F instruction is killed this cycle |
| pc_en | output | 1 | PC may update this cycle |

## Verification
The bench sets up matches on each source separately and on both at once. It pairs them with a store-like M instruction that does not write a register. A design that ignored `m_wr_reg` would stall needlessly, and one that compared only one source would let a stale operand through. It drives a redirect together with a live hazard: if stall won over flush, the wrong-path instruction would survive and the PC would freeze on the target. It also checks register 0 under both parameter settings and feeds the NOP word with hazardous-looking fields, which must neither stall nor leak a write. After every stall it checks that M holds a bubble and that the stall drops on the next cycle. A design that held the old M contents would repeat the writeback and stall forever.

// File: rtl/hz_pkg.sv
package hz_pkg;

    localparam int WORD_W  = 32;
    localparam int REGNO_W = 5;
    localparam logic [WORD_W-1:0] NOP_WORD = 32'h0000_000F;

    typedef logic [REGNO_W-1:0] regno_t;

    typedef struct packed {
        logic   wr_reg;
        logic   wr_mem;
        logic   rd_mem;
        logic   is_br;
        logic   is_jmp;
        regno_t dst;
    } ctl_t;

    typedef struct packed {
        regno_t a;
        regno_t b;
    } srcs_t;

    function automatic ctl_t bubble();
        ctl_t c;
        c = '0;
        return c;
    endfunction

    function automatic logic is_nop_word(input logic [WORD_W-1:0] w);
        return w == NOP_WORD;
    endfunction

    function automatic logic reg_exempt(input regno_t r, input bit zero_hw);
        return zero_hw && (r == '0);
    endfunction

endpackage

// File: rtl/hz_decode.sv
module hz_decode
    import hz_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    input  ctl_t              raw,
    output ctl_t              ctl,
    output logic              nop
);
    always_comb begin
        nop = is_nop_word(word);
        ctl = nop ? bubble() : raw;
    end
endmodule

// File: rtl/hz_detect.sv
module hz_detect
    import hz_pkg::*;
#(
    parameter bit ZERO_HARDWIRED = 1'b1
) (
    input  ctl_t  m_ctl,
    input  srcs_t srcs,
    input  logic  f_nop,
    output logic  hazard
);
    logic [1:0] hit;

    for (genvar i = 0; i < 2; i++) begin : g_cmp
        regno_t s;
        assign s      = (i == 0) ? srcs.a : srcs.b;
        assign hit[i] = (m_ctl.dst == s);
    end

    always_comb begin
        hazard = m_ctl.wr_reg && (|hit) && !f_nop
               && !reg_exempt(m_ctl.dst, ZERO_HARDWIRED);
    end
endmodule

// File: rtl/hz_pipe_reg.sv
module hz_pipe_reg
    import hz_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic flush,
    input  logic stall,
    input  ctl_t d,
    output ctl_t q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            q <= bubble();
        else if (flush)
            q <= bubble();
        else if (stall)
            q <= bubble();
        else
            q <= d;
    end
endmodule

// File: rtl/pipe_hazard_ctl.sv
module pipe_hazard_ctl
    import hz_pkg::*;
#(
    parameter bit ZERO_HARDWIRED = 1'b1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [31:0] f_word,
    input  logic        f_wr_reg,
    input  logic        f_wr_mem,
    input  logic        f_rd_mem,
    input  logic        f_is_br,
    input  logic        f_is_jmp,
    input  logic [4:0]  f_dst,
    input  logic [4:0]  f_src1,
    input  logic [4:0]  f_src2,
    input  logic        br_redirect,
    output logic        m_wr_reg,
    output logic        m_wr_mem,
    output logic        m_rd_mem,
    output logic        m_is_br,
    output logic        m_is_jmp,
    output logic [4:0]  m_dst,
    output logic        f_stall,
    output logic        f_flush,
    output logic        pc_en
);
    ctl_t  raw_c, f_c, m_c;
    srcs_t f_s;
    logic  f_nop, hazard;

    assign raw_c = '{wr_reg: f_wr_reg, wr_mem: f_wr_mem, rd_mem: f_rd_mem,
                     is_br: f_is_br, is_jmp: f_is_jmp, dst: f_dst};
    assign f_s   = '{a: f_src1, b: f_src2};

    hz_decode u_dec (
        .word (f_word),
        .raw  (raw_c),
        .ctl  (f_c),
        .nop  (f_nop)
    );

    hz_detect #(.ZERO_HARDWIRED(ZERO_HARDWIRED)) u_det (
        .m_ctl  (m_c),
        .srcs   (f_s),
        .f_nop  (f_nop),
        .hazard (hazard)
    );

    always_comb begin
        f_flush = br_redirect;
        f_stall = hazard && !br_redirect;
        pc_en   = !f_stall;
    end

    hz_pipe_reg u_mreg (
        .clk   (clk),
        .rst_n (rst_n),
        .flush (f_flush),
        .stall (f_stall),
        .d     (f_c),
        .q     (m_c)
    );

    assign m_wr_reg = m_c.wr_reg;
    assign m_wr_mem = m_c.wr_mem;
    assign m_rd_mem = m_c.rd_mem;
    assign m_is_br  = m_c.is_br;
    assign m_is_jmp = m_c.is_jmp;
    assign m_dst    = m_c.dst;
endmodule

// File: rtl/hz_checker.sv
module hz_checker (
    input logic        clk,
    input logic        rst_n,
    input logic [31:0] f_word,
    input logic        f_wr_reg,
    input logic [4:0]  f_dst,
    input logic [4:0]  f_src1,
    input logic        br_redirect,
    input logic        m_wr_reg,
    input logic        m_wr_mem,
    input logic        m_rd_mem,
    input logic        m_is_br,
    input logic        m_is_jmp,
    input logic [4:0]  m_dst,
    input logic        f_stall,
    input logic        f_flush,
    input logic        pc_en
);
    logic m_any;
    assign m_any = m_wr_reg | m_wr_mem | m_rd_mem | m_is_br | m_is_jmp | (|m_dst);

    always @(posedge clk) begin
        if (!rst_n) begin
            a_r1_reset_clear: assert (!m_any);
        end
    end

    a_r2_capture: assert property (@(posedge clk) disable iff (!rst_n)
        (!f_stall && !f_flush && f_word != 32'h0000000F)
        |=> (m_dst == $past(f_dst) && m_wr_reg == $past(f_wr_reg)));

    a_r3_stall_on_match: assert property (@(posedge clk) disable iff (!rst_n)
        (m_wr_reg && m_dst == f_src1 && m_dst != 5'd0 && !br_redirect
         && f_word != 32'h0000000F) |-> f_stall);

    a_r4_no_stall_without_write: assert property (@(posedge clk) disable iff (!rst_n)
        !m_wr_reg |-> !f_stall);

    a_r5_stall_bubble: assert property (@(posedge clk) disable iff (!rst_n)
        f_stall |=> !m_any);

    a_r5_pc_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        f_stall |-> !pc_en);

    a_r6_flush_bubble: assert property (@(posedge clk) disable iff (!rst_n)
        f_flush |=> !m_any);

    a_r6_flush_wins: assert property (@(posedge clk) disable iff (!rst_n)
        f_flush |-> (!f_stall && pc_en));

    a_r7_nop_no_stall: assert property (@(posedge clk) disable iff (!rst_n)
        (f_word == 32'h0000000F) |-> !f_stall);

    a_r9_progress: assert property (@(posedge clk) disable iff (!rst_n)
        f_stall |=> !f_stall);
endmodule

bind pipe_hazard_ctl hz_checker u_hz_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .f_word      (f_word),
    .f_wr_reg    (f_wr_reg),
    .f_dst       (f_dst),
    .f_src1      (f_src1),
    .br_redirect (br_redirect),
    .m_wr_reg    (m_wr_reg),
    .m_wr_mem    (m_wr_mem),
    .m_rd_mem    (m_rd_mem),
    .m_is_br     (m_is_br),
    .m_is_jmp    (m_is_jmp),
    .m_dst       (m_dst),
    .f_stall     (f_stall),
    .f_flush     (f_flush),
    .pc_en       (pc_en)
);

// File: tb/test_pipe_hazard_ctl.sv
module test_pipe_hazard_ctl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b1;
    logic [31:0] f_word = 32'h0;
    logic        f_wr_reg = 0, f_wr_mem = 0, f_rd_mem = 0, f_is_br = 0, f_is_jmp = 0;
    logic [4:0]  f_dst = 0, f_src1 = 0, f_src2 = 0;
    logic        br_redirect = 0;

    logic        m_wr_reg, m_wr_mem, m_rd_mem, m_is_br, m_is_jmp;
    logic [4:0]  m_dst;
    logic        f_stall, f_flush, pc_en;

    logic        r_wr_reg, r_wr_mem, r_rd_mem, r_is_br, r_is_jmp;
    logic [4:0]  r_dst;
    logic        r_stall, r_flush, r_pc_en;

    int n_chk = 0;
    int n_bad = 0;
    int stall_run = 0;
    bit done = 0;

    // reference M state: [0]=zero-hardwired instance, [1]=plain instance
    logic [9:0] ref_m [2];

    always #2 clk = ~clk;

    pipe_hazard_ctl i_pipe_hazard_ctl (
        .clk, .rst_n, .f_word, .f_wr_reg, .f_wr_mem, .f_rd_mem, .f_is_br,
        .f_is_jmp, .f_dst, .f_src1, .f_src2, .br_redirect,
        .m_wr_reg, .m_wr_mem, .m_rd_mem, .m_is_br, .m_is_jmp, .m_dst,
        .f_stall, .f_flush, .pc_en
    );

    pipe_hazard_ctl #(.ZERO_HARDWIRED(1'b0)) i_pipe_hazard_ctl_r0 (
        .clk, .rst_n, .f_word, .f_wr_reg, .f_wr_mem, .f_rd_mem, .f_is_br,
        .f_is_jmp, .f_dst, .f_src1, .f_src2, .br_redirect,
        .m_wr_reg(r_wr_reg), .m_wr_mem(r_wr_mem), .m_rd_mem(r_rd_mem),
        .m_is_br(r_is_br), .m_is_jmp(r_is_jmp), .m_dst(r_dst),
        .f_stall(r_stall), .f_flush(r_flush), .pc_en(r_pc_en)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    // M layout in model: {wr_reg, wr_mem, rd_mem, is_br, is_jmp, dst}
    function automatic logic model_hazard(input logic [9:0] m, input bit zhw);
        if (f_word == 32'h0000000F) return 1'b0;                 // R7
        if (!m[9]) return 1'b0;                                   // R4
        if (zhw && m[4:0] == 5'd0) return 1'b0;                   // R8
        return (m[4:0] == f_src1) || (m[4:0] == f_src2);          // R3
    endfunction

    task automatic step(input string tag);
        logic [9:0] f_ctl;
        // compare M state (settled since last edge)
        chk({tag, " R2 M state"},
            {22'd0, m_wr_reg, m_wr_mem, m_rd_mem, m_is_br, m_is_jmp, m_dst}, {22'd0, ref_m[0]});
        chk({tag, " R8 M state (r0 live)"},
            {22'd0, r_wr_reg, r_wr_mem, r_rd_mem, r_is_br, r_is_jmp, r_dst}, {22'd0, ref_m[1]});
        #1;
        f_ctl = (f_word == 32'h0000000F) ? 10'd0
              : {f_wr_reg, f_wr_mem, f_rd_mem, f_is_br, f_is_jmp, f_dst};
        for (int k = 0; k < 2; k++) begin
            logic hz, st;
            hz = model_hazard(ref_m[k], k == 0);
            st = hz && !br_redirect;                              // R6 flush wins
            if (k == 0) begin
                chk({tag, " R3 stall"}, {31'd0, f_stall}, {31'd0, st});
                chk({tag, " R5 pc_en"}, {31'd0, pc_en}, {31'd0, !st});
                chk({tag, " R6 flush"}, {31'd0, f_flush}, {31'd0, br_redirect});
                if (st) stall_run++; else stall_run = 0;
                chk({tag, " R9 progress"}, {31'd0, stall_run > 1}, 32'd0);
            end else begin
                chk({tag, " R8 stall r0 live"}, {31'd0, r_stall}, {31'd0, st});
            end
            ref_m[k] = (st || br_redirect) ? 10'd0 : f_ctl;
        end
    endtask

    task automatic drive(input logic [31:0] w, input logic [4:0] ctl5,
                         input logic [4:0] d, input logic [4:0] s1, input logic [4:0] s2,
                         input logic rd);
        @(negedge clk);
        f_word = w;
        {f_wr_reg, f_wr_mem, f_rd_mem, f_is_br, f_is_jmp} = ctl5;
        f_dst = d; f_src1 = s1; f_src2 = s2; br_redirect = rd;
    endtask

    task automatic vec(input string tag, input logic [31:0] w, input logic [4:0] ctl5,
                       input logic [4:0] d, input logic [4:0] s1, input logic [4:0] s2,
                       input logic rd);
        @(negedge clk);
        step_pre(tag, w, ctl5, d, s1, s2, rd);
    endtask

    task automatic step_pre(input string tag, input logic [31:0] w, input logic [4:0] ctl5,
                            input logic [4:0] d, input logic [4:0] s1, input logic [4:0] s2,
                            input logic rd);
        chk({tag, " R2 M state"},
            {22'd0, m_wr_reg, m_wr_mem, m_rd_mem, m_is_br, m_is_jmp, m_dst}, {22'd0, ref_m[0]});
        f_word = w;
        {f_wr_reg, f_wr_mem, f_rd_mem, f_is_br, f_is_jmp} = ctl5;
        f_dst = d; f_src1 = s1; f_src2 = s2; br_redirect = rd;
        step(tag);
    endtask

    initial begin
        #1 rst_n = 1'b0;
        ref_m[0] = '0; ref_m[1] = '0;
        @(negedge clk);
        @(negedge clk);
        chk("R1 reset M zero",
            {22'd0, m_wr_reg, m_wr_mem, m_rd_mem, m_is_br, m_is_jmp, m_dst}, 32'd0);
        chk("R1 reset M zero (r0 live)",
            {22'd0, r_wr_reg, r_wr_mem, r_rd_mem, r_is_br, r_is_jmp, r_dst}, 32'd0);
        rst_n = 1'b1;

        // ctl5 = {wr_reg, wr_mem, rd_mem, is_br, is_jmp}
        vec("R2 write r3",         32'h1, 5'b10000, 5'd3, 5'd1, 5'd2, 0);
        vec("R3 src1 match",       32'h2, 5'b10000, 5'd4, 5'd3, 5'd2, 0);
        vec("R3 held after stall", 32'h2, 5'b10000, 5'd4, 5'd3, 5'd2, 0);
        vec("R3 src2 match",       32'h3, 5'b00100, 5'd5, 5'd1, 5'd4, 0);
        vec("R4 after load",       32'h4, 5'b01000, 5'd0, 5'd9, 5'd9, 0);
        vec("R4 store in M",       32'h5, 5'b10000, 5'd7, 5'd0, 5'd0, 0);
        vec("R4 no match",         32'h6, 5'b10000, 5'd8, 5'd1, 5'd2, 0);
        vec("R6 flush over hazard",32'h7, 5'b11111, 5'd9, 5'd8, 5'd8, 1);
        vec("R6 after flush",      32'h8, 5'b10000, 5'd0, 5'd0, 5'd0, 0);
        vec("R8 zero dst match",   32'h9, 5'b10000, 5'd1, 5'd0, 5'd0, 0);
        vec("R8 follow",           32'h9, 5'b10000, 5'd1, 5'd0, 5'd0, 0);
        vec("R7 nop with fields",  32'h0000000F, 5'b11111, 5'd1, 5'd1, 5'd1, 0);
        vec("R7 after nop",        32'hA, 5'b00010, 5'd2, 5'd1, 5'd1, 0);
        vec("R2 jump",             32'hB, 5'b00001, 5'd0, 5'd3, 5'd3, 0);

        for (int i = 0; i < 3000; i++) begin
            logic [31:0] w;
            w = ($urandom % 6 == 0) ? 32'h0000000F : $urandom;
            vec("rand", w, 5'($urandom), 5'($urandom % 6), 5'($urandom % 6),
                5'($urandom % 6), ($urandom % 7) == 0);
        end

        @(negedge clk);
        rst_n = 1'b0;
        #1;
        chk("R1 async reset mid-run",
            {22'd0, m_wr_reg, m_wr_mem, m_rd_mem, m_is_br, m_is_jmp, m_dst}, 32'd0);
        done = 1;
    end

    initial begin
        for (int c = 0; c < 100000 && !done; c++) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=hung expected=done");
        end
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    // unused helper kept callable for directed single-field drives
    initial if (0) drive(32'h0, 5'd0, 5'd0, 5'd0, 5'd0, 1'b0);
endmodule